// File: doc/BRIEF.md
# In-Order Pipeline Hazard Interlock

This block holds the stall control for a single-issue, in-order pipeline with five stages: fetch, decode, execute, memory and writeback. Besides the one-cycle integer execute stage, the pipeline has two longer floating-point execute paths, a four-stage adder and a seven-stage multiplier. There is no operand forwarding. Branches test a register for zero and are resolved in decode. Every cycle the unit looks at the decoded register fields and the operation class of the instruction in decode. It decides whether that instruction may leave decode. If it may not, the unit holds fetch and decode and sends a no-op into execute. When a branch resolves taken, the unit raises a redirect enable.

The unit follows every register-writing instruction still in flight without being told about it. A per-register countdown gives the number of cycles left until that register's writeback. A shift register marks the future cycles in which writeback is already claimed. From these it finds three things: reads of values that are not yet written (RAW), writes that would finish ahead of an older write to the same register (WAW), and two writes that would land in the same writeback cycle. The register file writes early in the writeback cycle and reads late in it, so a consumer may leave decode in the same cycle as its producer's writeback.

Top module: `hz_interlock`

## Requirements
- R1: After reset, and after any later reset, no write is pending. An instruction in decode that reads or writes any register leaves without a stall. While reset is active, `if_id_hold`, `ex_bubble` and `br_redirect` are low.
- R2: A producer leaves decode in cycle t and writes register x. Its writeback falls in cycle t+3 for class 0 (integer, load, store; one execute stage), t+6 for class 1 (FP add) and t+9 for class 2 (FP multiply). An instruction in decode that reads x (with `id_rs1_rd` or `id_rs2_rd` set) is held in every cycle before that writeback cycle.
- R3: In the producer's writeback cycle the consumer is no longer held for that register.
- R4: An instruction in decode that writes register x, with distance d to its own writeback, is held while an older write to x is due d or more cycles later. Once the older write is due first, it is released.
- R5: A register-writing instruction is held while its writeback cycle is already claimed by an older register write. At most one register write completes per cycle.
- R6: A write to a register that an older in-flight instruction only read causes no stall (WAR).
- R7: Register 0 never causes a stall, as a source or as a destination, and a write to it claims no writeback cycle.
- R8: Classes 3 (branch if zero) and 4 (branch if nonzero) use `id_rs1` and are held until it is readable, as in R2 and R3. In the cycle a branch leaves decode, `br_redirect` equals `id_rs1_zero` for class 3 and its inverse for class 4. In any other cycle it stays low, and branches write no register.
- R9: `if_id_hold` and `ex_bubble` are both high in exactly the cycles a valid instruction is held. With `id_valid` low, all three outputs are low and no state is claimed.
- R10: Instructions in different execute paths that share no registers and have different writeback cycles leave decode on consecutive cycles without a stall.
- R11: No instruction is held for more than 8 consecutive cycles (multiplier writeback distance minus one).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_valid | input | 1 | An instruction is present in decode |
| id_cls | input | 3 | Operation class: 0 integer/load/store, 1 FP add, 2 FP multiply, 3 branch if zero, 4 branch if nonzero |
| id_rs1 | input | 5 | First source register index |
| id_rs1_rd | input | 1 | First source is read |
| id_rs2 | input | 5 | Second source register index |
| id_rs2_rd | input | 1 | Second source is read |
| id_rd | input | 5 | Destination register index |
| id_rd_wr | input | 1 | Destination is written |
| id_rs1_zero | input | 1 | The value read for the first source equals zero (branch test) |
| if_id_hold | output | 1 | Hold the fetch and decode registers |
| ex_bubble | output | 1 | Send a no-op into execute this cycle |
| br_redirect | output | 1 | A branch leaving decode is taken; redirect fetch |

## Verification
All three outputs are combinational on the decode fields and on registered tracking state. A decision therefore belongs to the cycle in which the instruction sits in decode. The bench drives each instruction just after a falling edge and samples the outputs one time step later, in the same low phase. It counts the samples showing a hold until the first one that shows release. It then compares that count with the cycle model kept in the bench. In that model a write issued in cycle e becomes readable in cycle e+3, e+6 or e+9 and claims that writeback slot. State changes only at the rising edge that ends a release sample, so the next instruction is judged against the updated tracking one cycle later.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Operation classes presented in decode. Unlisted codes behave as integer.
  typedef enum logic [2:0] {
    OPC_ALU  = 3'd0,
    OPC_FADD = 3'd1,
    OPC_FMUL = 3'd2,
    OPC_BRZ  = 3'd3,
    OPC_BRNZ = 3'd4
  } opc_e;

  function automatic logic opc_is_branch(input logic [2:0] cls);
    return (cls == OPC_BRZ) || (cls == OPC_BRNZ);
  endfunction

endpackage

// File: rtl/hz_pend_tbl.sv
// Per-register countdown of cycles left until the pending writeback.
module hz_pend_tbl #(
  parameter int NUM_REGS = 32,
  parameter int RIDX_W   = 5,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [RIDX_W-1:0] set_idx,
  input  logic [CNT_W-1:0]  set_cnt,
  input  logic [RIDX_W-1:0] rd_idx_a,
  input  logic [RIDX_W-1:0] rd_idx_b,
  input  logic [RIDX_W-1:0] rd_idx_c,
  output logic [CNT_W-1:0]  cnt_a,
  output logic [CNT_W-1:0]  cnt_b,
  output logic [CNT_W-1:0]  cnt_c
);

  logic [CNT_W-1:0] cnt_q [NUM_REGS];

  // Register 0 is never tracked.
  assign cnt_q[0] = '0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_entry
    logic             hit;
    logic             en;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
      hit   = set_en && (set_idx == RIDX_W'(g));
      en    = hit || (cnt_q[g] != '0);
      cnt_d = hit ? set_cnt : (cnt_q[g] - CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
      end else if (en) begin
        cnt_q[g] <= cnt_d;
      end
    end
  end

  always_comb begin
    cnt_a = cnt_q[rd_idx_a];
    cnt_b = cnt_q[rd_idx_b];
    cnt_c = cnt_q[rd_idx_c];
  end

endmodule

// File: rtl/hz_wb_slots.sv
// Bit k set: a register write completes k cycles from now.
module hz_wb_slots #(
  parameter int DEPTH = 10,
  parameter int DIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claim,
  input  logic [DIST_W-1:0] claim_dist,
  input  logic [DIST_W-1:0] query_dist,
  output logic              query_busy
);

  logic [DEPTH-1:0] slot_q;
  logic [DEPTH-1:0] slot_d;
  logic [DEPTH-1:0] claim_vec;

  always_comb begin
    claim_vec = '0;
    // Claimed distance d is seen as d-1 after the next edge.
    for (int k = 1; k < DEPTH; k++) begin
      if (claim && (claim_dist == DIST_W'(k))) claim_vec[k-1] = 1'b1;
    end
    slot_d = (slot_q >> 1) | claim_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_d;
    end
  end

  always_comb begin
    query_busy = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (query_dist == DIST_W'(k)) query_busy = slot_q[k];
    end
  end

endmodule

// File: rtl/hz_stall_ctl.sv
// Combinational issue decision for the instruction in decode.
module hz_stall_ctl
  import hz_pkg::*;
#(
  parameter int WB_ALU  = 3,
  parameter int WB_FADD = 6,
  parameter int WB_FMUL = 9,
  parameter int CNT_W   = 4
) (
  input  logic             id_valid,
  input  logic [2:0]       id_cls,
  input  logic             rs1_use,
  input  logic             rs2_use,
  input  logic             rd_use,
  input  logic [CNT_W-1:0] cnt_rs1,
  input  logic [CNT_W-1:0] cnt_rs2,
  input  logic [CNT_W-1:0] cnt_rd,
  input  logic             slot_busy,
  input  logic             rs1_zero,
  output logic [CNT_W-1:0] wb_dist,
  output logic             stall,
  output logic             wr_issue,
  output logic             redirect
);

  logic is_br;
  logic writes;
  logic raw_hit;
  logic waw_hit;
  logic col_hit;
  logic taken;

  always_comb begin
    unique case (id_cls)
      OPC_FADD: wb_dist = CNT_W'(WB_FADD);
      OPC_FMUL: wb_dist = CNT_W'(WB_FMUL);
      default:  wb_dist = CNT_W'(WB_ALU);
    endcase
  end

  always_comb begin
    is_br   = opc_is_branch(id_cls);
    writes  = rd_use && !is_br;
    raw_hit = (rs1_use && (cnt_rs1 != '0)) || (rs2_use && (cnt_rs2 != '0));
    waw_hit = writes && (cnt_rd >= wb_dist);
    col_hit = writes && slot_busy;
    stall   = id_valid && (raw_hit || waw_hit || col_hit);
    wr_issue = id_valid && !stall && writes;
    taken   = (id_cls == OPC_BRZ) ? rs1_zero : !rs1_zero;
    redirect = id_valid && !stall && is_br && taken;
  end

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
  import hz_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int EX_ALU   = 1,
  parameter int EX_FADD  = 4,
  parameter int EX_FMUL  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       id_valid,
  input  logic [2:0] id_cls,
  input  logic [4:0] id_rs1,
  input  logic       id_rs1_rd,
  input  logic [4:0] id_rs2,
  input  logic       id_rs2_rd,
  input  logic [4:0] id_rd,
  input  logic       id_rd_wr,
  input  logic       id_rs1_zero,
  output logic       if_id_hold,
  output logic       ex_bubble,
  output logic       br_redirect
);

  localparam int RIDX_W  = $clog2(NUM_REGS);
  localparam int WB_ALU  = EX_ALU + 2;
  localparam int WB_FADD = EX_FADD + 2;
  localparam int WB_FMUL = EX_FMUL + 2;
  localparam int WB_MAX  = (WB_FMUL > WB_FADD) ? WB_FMUL : WB_FADD;
  localparam int CNT_W   = $clog2(WB_MAX + 1);
  localparam int SLOTS   = WB_MAX + 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [RIDX_W-1:0] rs1_i;
  logic [RIDX_W-1:0] rs2_i;
  logic [RIDX_W-1:0] rd_i;
  logic              rs1_use;
  logic              rs2_use;
  logic              rd_use;

  always_comb begin
    rs1_i   = RIDX_W'(id_rs1);
    rs2_i   = RIDX_W'(id_rs2);
    rd_i    = RIDX_W'(id_rd);
    rs1_use = id_rs1_rd && (rs1_i != '0);
    rs2_use = id_rs2_rd && (rs2_i != '0);
    rd_use  = id_rd_wr && (rd_i != '0);
  end

  logic [CNT_W-1:0] cnt_rs1;
  logic [CNT_W-1:0] cnt_rs2;
  logic [CNT_W-1:0] cnt_rd;
  logic [CNT_W-1:0] wb_dist;
  logic             slot_busy;
  logic             stall;
  logic             wr_issue;
  logic             redirect;

  hz_pend_tbl #(
    .NUM_REGS (NUM_REGS),
    .RIDX_W   (RIDX_W),
    .CNT_W    (CNT_W)
  ) u_pend (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_en   (wr_issue),
    .set_idx  (rd_i),
    .set_cnt  (wb_dist - CNT_W'(1)),
    .rd_idx_a (rs1_i),
    .rd_idx_b (rs2_i),
    .rd_idx_c (rd_i),
    .cnt_a    (cnt_rs1),
    .cnt_b    (cnt_rs2),
    .cnt_c    (cnt_rd)
  );

  hz_wb_slots #(
    .DEPTH  (SLOTS),
    .DIST_W (CNT_W)
  ) u_slots (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .claim      (wr_issue),
    .claim_dist (wb_dist),
    .query_dist (wb_dist),
    .query_busy (slot_busy)
  );

  hz_stall_ctl #(
    .WB_ALU  (WB_ALU),
    .WB_FADD (WB_FADD),
    .WB_FMUL (WB_FMUL),
    .CNT_W   (CNT_W)
  ) u_ctl (
    .id_valid (id_valid),
    .id_cls   (id_cls),
    .rs1_use  (rs1_use),
    .rs2_use  (rs2_use),
    .rd_use   (rd_use),
    .cnt_rs1  (cnt_rs1),
    .cnt_rs2  (cnt_rs2),
    .cnt_rd   (cnt_rd),
    .slot_busy(slot_busy),
    .rs1_zero (id_rs1_zero),
    .wb_dist  (wb_dist),
    .stall    (stall),
    .wr_issue (wr_issue),
    .redirect (redirect)
  );

  always_comb begin
    if_id_hold  = stall && rst_sync_n;
    ex_bubble   = stall && rst_sync_n;
    br_redirect = redirect && rst_sync_n;
  end

endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk #(
  parameter int MAX_HOLD = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       id_valid,
  input logic [2:0] id_cls,
  input logic [4:0] id_rs1,
  input logic       id_rs1_rd,
  input logic [4:0] id_rs2,
  input logic       id_rs2_rd,
  input logic [4:0] id_rd,
  input logic       id_rd_wr,
  input logic       if_id_hold,
  input logic       ex_bubble,
  input logic       br_redirect
);

  logic       seen_q;
  logic [7:0] hold_run_q;
  logic       wrote;
  logic       left_id;

  always_comb begin
    left_id = id_valid && !if_id_hold;
    wrote   = left_id && id_rd_wr && (id_rd != 5'd0) && (id_cls != 3'd3) && (id_cls != 3'd4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= 1'b0;
      hold_run_q <= '0;
    end else begin
      seen_q <= 1'b1;
      if (if_id_hold) begin
        if (hold_run_q != 8'hff) hold_run_q <= hold_run_q + 8'd1;
      end else begin
        hold_run_q <= '0;
      end
    end
  end

  // R2: a reader right behind the writer of its source waits.
  assert_raw_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(wrote) && id_valid && id_rs1_rd && (id_rs1 == $past(id_rd)))
      |-> if_id_hold);

  // R4: an integer write right behind a multiply to the same register waits.
  assert_waw_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(wrote) && ($past(id_cls) == 3'd2) && id_valid && (id_cls == 3'd0)
      && id_rd_wr && (id_rd == $past(id_rd)))
      |-> if_id_hold);

  // R7: an instruction touching only register 0 is never held.
  assert_r0_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && (!id_rs1_rd || id_rs1 == 5'd0) && (!id_rs2_rd || id_rs2 == 5'd0)
      && (!id_rd_wr || id_rd == 5'd0))
      |-> !if_id_hold);

  // R8: a redirect only comes from a branch leaving decode.
  assert_redirect_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    br_redirect |-> (id_valid && !if_id_hold && ((id_cls == 3'd3) || (id_cls == 3'd4))));

  // R9: nothing in decode means no hold, no bubble, no redirect.
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> (!if_id_hold && !ex_bubble && !br_redirect));

  // R9: hold and bubble move together.
  assert_hold_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
    if_id_hold == ex_bubble);

  // R11: bounded hold run.
  assert_hold_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_run_q >= 8'(MAX_HOLD)) |-> !if_id_hold);

endmodule

bind hz_interlock hz_interlock_chk #(
  .MAX_HOLD (WB_FMUL - 1)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .id_valid    (id_valid),
  .id_cls      (id_cls),
  .id_rs1      (id_rs1),
  .id_rs1_rd   (id_rs1_rd),
  .id_rs2      (id_rs2),
  .id_rs2_rd   (id_rs2_rd),
  .id_rd       (id_rd),
  .id_rd_wr    (id_rd_wr),
  .if_id_hold  (if_id_hold),
  .ex_bubble   (ex_bubble),
  .br_redirect (br_redirect)
);

// File: tb/tb_hz_interlock.sv
`timescale 1ns/1ps
module tb_hz_interlock;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       id_valid;
  logic [2:0] id_cls;
  logic [4:0] id_rs1;
  logic       id_rs1_rd;
  logic [4:0] id_rs2;
  logic       id_rs2_rd;
  logic [4:0] id_rd;
  logic       id_rd_wr;
  logic       id_rs1_zero;
  logic       if_id_hold;
  logic       ex_bubble;
  logic       br_redirect;

  always #10 clk = ~clk;

  hz_interlock dut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_cls(id_cls),
    .id_rs1(id_rs1), .id_rs1_rd(id_rs1_rd), .id_rs2(id_rs2), .id_rs2_rd(id_rs2_rd),
    .id_rd(id_rd), .id_rd_wr(id_rd_wr), .id_rs1_zero(id_rs1_zero),
    .if_id_hold(if_id_hold), .ex_bubble(ex_bubble), .br_redirect(br_redirect)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // Cycle model: writeback cycle per register, claimed writeback cycles.
  int ready_c [32];
  int slot_c  [16];

  function automatic int wb_of(input int cls);
    if (cls == 1) return 6;
    if (cls == 2) return 9;
    return 3;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 32; i++) ready_c[i] = 0;
    for (int i = 0; i < 16; i++) slot_c[i] = -1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Drive one instruction, count held cycles, compare with the model.
  task automatic send(input int cls, input int rd, input bit rdw,
                      input int rs1, input bit r1e, input int rs2, input bit r2e,
                      input bit zf, input string req);
    int now, e, lat, stalls, tries;
    bit br, ok, exp_red, got_red;
    @(negedge clk);
    id_valid = 1'b1; id_cls = 3'(cls); id_rd = 5'(rd); id_rd_wr = rdw;
    id_rs1 = 5'(rs1); id_rs1_rd = r1e; id_rs2 = 5'(rs2); id_rs2_rd = r2e;
    id_rs1_zero = zf;
    #1;
    now = cyc; lat = wb_of(cls); br = (cls == 3) || (cls == 4);
    e = now;
    for (int k = 0; k < 40; k++) begin
      ok = 1'b1;
      if (r1e && rs1 != 0 && ready_c[rs1] > e) ok = 1'b0;
      if (r2e && rs2 != 0 && ready_c[rs2] > e) ok = 1'b0;
      if (!br && rdw && rd != 0) begin
        if (ready_c[rd] >= e + lat) ok = 1'b0;
        if (slot_c[(e + lat) % 16] == e + lat) ok = 1'b0;
      end
      if (ok) break;
      e++;
    end
    stalls = 0; tries = 0; got_red = 1'b0;
    while (if_id_hold && tries < 30) begin
      if (ex_bubble !== 1'b1) check(1'b0, "R9 bubble", ex_bubble, 1);
      if (br_redirect) got_red = 1'b1;
      stalls++; tries++;
      @(negedge clk); #1;
    end
    if (tries >= 30) check(1'b0, "watchdog", tries, e - now);
    check(stalls == e - now, req, stalls, e - now);
    check(stalls <= 8, "R11", stalls, 8);
    check(ex_bubble == 1'b0, "R9 bubble", ex_bubble, 0);
    exp_red = br && ((cls == 3) ? zf : !zf);
    check(br_redirect == exp_red && !got_red, "R8 redirect", br_redirect, exp_red);
    if (!br && rdw && rd != 0) begin
      ready_c[rd] = e + lat;
      slot_c[(e + lat) % 16] = e + lat;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      id_valid = 1'b0; id_rd_wr = 1'b1; id_rs1_rd = 1'b1; id_rs2_rd = 1'b1;
      #1;
      check(!if_id_hold && !ex_bubble && !br_redirect, "R9 idle",
            {if_id_hold, ex_bubble, br_redirect}, 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; id_valid = 1'b0;
    #1;
    check(!if_id_hold && !ex_bubble && !br_redirect, "R1 reset outputs",
          {if_id_hold, ex_bubble, br_redirect}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clear();
  endtask

  task automatic t_raw();
    send(0, 1, 1, 0, 0, 0, 0, 0, "R2 alu prod");
    send(0, 2, 1, 1, 1, 0, 0, 0, "R2 R3 alu raw");
    send(1, 3, 1, 0, 0, 0, 0, 0, "R2 fadd prod");
    send(0, 4, 1, 0, 0, 3, 1, 0, "R2 R3 fadd raw");
    send(2, 5, 1, 0, 0, 0, 0, 0, "R2 fmul prod");
    send(0, 6, 1, 5, 1, 0, 0, 0, "R2 R3 fmul raw");
    send(0, 7, 1, 0, 0, 0, 0, 0, "R2 gap prod");
    idle(1);
    send(0, 8, 1, 7, 1, 0, 0, 0, "R3 gap raw");
  endtask

  task automatic t_waw();
    send(2, 9, 1, 0, 0, 0, 0, 0, "R4 fmul");
    send(0, 9, 1, 0, 0, 0, 0, 0, "R4 alu after fmul");
    send(1, 10, 1, 0, 0, 0, 0, 0, "R4 fadd");
    send(0, 10, 1, 0, 0, 0, 0, 0, "R4 alu after fadd");
    send(2, 11, 1, 0, 0, 0, 0, 0, "R4 fmul2");
    send(1, 11, 1, 0, 0, 0, 0, 0, "R4 fadd after fmul");
  endtask

  task automatic t_collide();
    idle(10);
    send(2, 12, 1, 0, 0, 0, 0, 0, "R5 fmul");
    idle(5);
    send(0, 13, 1, 0, 0, 0, 0, 0, "R5 alu same slot");
    idle(10);
    send(1, 14, 1, 0, 0, 0, 0, 0, "R5 fadd");
    idle(2);
    send(0, 15, 1, 0, 0, 0, 0, 0, "R5 alu vs fadd");
    send(0, 0, 0, 0, 0, 0, 0, 0, "R5 store no write");
  endtask

  task automatic t_war();
    idle(10);
    send(2, 16, 1, 17, 1, 18, 1, 0, "R6 reader");
    send(0, 17, 1, 19, 1, 0, 0, 0, "R6 war write");
    send(0, 18, 1, 0, 0, 0, 0, 0, "R6 war write2");
  endtask

  task automatic t_r0();
    idle(10);
    send(2, 0, 1, 0, 0, 0, 0, 0, "R7 fmul r0");
    send(0, 0, 1, 0, 1, 0, 1, 0, "R7 read r0");
    idle(4);
    send(0, 0, 1, 0, 0, 0, 0, 0, "R7 slot r0");
  endtask

  task automatic t_branch();
    idle(10);
    send(0, 20, 1, 0, 0, 0, 0, 0, "R8 prod");
    send(3, 0, 0, 20, 1, 0, 0, 1, "R8 brz taken");
    send(4, 0, 0, 0, 0, 0, 0, 1, "R8 brnz not taken");
    send(2, 21, 1, 0, 0, 0, 0, 0, "R8 fmul prod");
    send(4, 0, 0, 21, 1, 0, 0, 0, "R8 brnz taken");
    send(3, 21, 1, 0, 0, 0, 0, 0, "R8 branch writes nothing");
    send(0, 22, 1, 21, 1, 0, 0, 0, "R8 no claim by branch");
  endtask

  task automatic t_idle_hazard();
    idle(10);
    send(2, 23, 1, 0, 0, 0, 0, 0, "R9 prod");
    idle(3);
    send(0, 24, 1, 23, 1, 0, 0, 0, "R9 after idle");
  endtask

  task automatic t_parallel();
    idle(10);
    send(1, 25, 1, 0, 0, 0, 0, 0, "R10 fadd");
    send(2, 26, 1, 0, 0, 0, 0, 0, "R10 fmul");
    send(0, 27, 1, 0, 0, 0, 0, 0, "R10 alu");
    send(0, 28, 1, 0, 0, 0, 0, 0, "R10 alu2");
  endtask

  task automatic t_mix();
    int cls, rd, s1, s2;
    idle(10);
    for (int i = 0; i < 60; i++) begin
      cls = (i * 7 + 3) % 5;
      rd  = (i * 5 + 1) % 8;
      s1  = (i * 3 + 2) % 8;
      s2  = (i * 11 + 5) % 8;
      send(cls, rd, 1, s1, 1, s2, (i % 3) != 0, i[0], "R11 mix");
    end
  endtask

  task automatic t_reset_mid();
    send(2, 29, 1, 0, 0, 0, 0, 0, "R1 pre-reset");
    do_reset();
    send(0, 29, 1, 29, 1, 0, 0, 0, "R1 cleared");
  endtask

  initial begin
    rst_n = 1'b0; id_valid = 1'b0; id_cls = '0; id_rs1 = '0; id_rs1_rd = 1'b0;
    id_rs2 = '0; id_rs2_rd = 1'b0; id_rd = '0; id_rd_wr = 1'b0; id_rs1_zero = 1'b0;
    model_clear();
    do_reset();
    send(1, 30, 1, 31, 1, 30, 1, 0, "R1 first after reset");
    t_raw();
    t_waw();
    t_collide();
    t_war();
    t_r0();
    t_branch();
    t_idle_hazard();
    t_parallel();
    t_mix();
    t_reset_mid();
    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule